// File: doc/BRIEF.md
# Per-Second Error Performance Classifier

This block turns a stream of per-block error indications into one-second performance records. Every block arrives as a one-cycle strobe carrying an errored flag. A loss-of-signal flag marks blocks that were received while the signal was absent, and such blocks count as errored. A one-cycle tick closes each second. For every closed second the block decides three things: whether the second is errored, whether it is severely errored, and whether it falls inside unavailable time. It then reports the second's background-block-error count and keeps running totals.

A second is severely errored in either of two cases. The first is when its errored-block share is above a percentage threshold. The second is when it holds a run of consecutive errored blocks long enough to form a disturbance period. Unavailable time starts after a run of consecutive severely errored seconds, and those seconds are themselves relabelled as unavailable. It ends after an equally long run of seconds that are not severely errored, and those seconds are relabelled as available. To make the relabelling possible, each second's record is held in a short line before it is reported.

Separately, a fixed-length block window is watched for error density. The window drives a signal-degrade alarm and an excessive-error alarm.

Top module: `err_second_classifier`

## Requirements
- R1: A reported second whose block count includes at least one errored block has `sec_es`=1, unless it is unavailable.
- R2: A second is severely errored when 100 × errored blocks > SES_PCT × blocks in that second (default SES_PCT = 30).
- R3: A second is also severely errored when it contains a run of SDP_LEN or more consecutive errored blocks (default 8, the 1 ms span at 8000 blocks per second), even if the ratio test of R2 fails.
- R4: A block with `sig_loss`=1 counts as an errored block for R1, R2, R3 and R7, whatever `blk_err` is.
- R5: When RUN_LEN consecutive seconds (default 10) are severely errored, unavailable time begins with the first of them. Those seconds and all later ones report `sec_uas`=1 with `sec_es`=0, `sec_ses`=0 and `sec_bbe`=0.
- R6: During unavailable time, RUN_LEN consecutive seconds that are not severely errored end it from the first of them. Those seconds report `sec_uas`=0 with their normal flags.
- R7: `sec_bbe` equals the errored-block count of a second that is available and not severely errored, and is 0 otherwise.
- R8: `cses_total` counts runs of 2 or more consecutive available severely errored seconds. A run is counted when it ends, meaning the next reported second is not an available severely errored second.
- R9: The record for second k is reported with a one-cycle `sec_valid` pulse, 3 clock edges after the tick that closes second k+RUN_LEN. Nothing is reported before RUN_LEN seconds have been collected.
- R10: `es_total`, `ses_total`, `uas_total` and `bbe_total` accumulate the reported `sec_es`, `sec_ses`, `sec_uas` and `sec_bbe` values.
- R11: At the end of each window of WIN_BLK blocks, `sd_alarm` is set if the window held at least max(1, WIN_BLK/SD_DIV) errored blocks, and is cleared otherwise.
- R12: At the end of each window, `exc_alarm` is set if the window held at least max(1, WIN_BLK/EXC_DIV) errored blocks, and is cleared otherwise. Both alarms change on the edge that accepts the window's last block.
- R13: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | One block is present this cycle |
| blk_err | input | 1 | The present block is errored |
| sig_loss | input | 1 | Signal lost while the present block was received |
| sec_tick | input | 1 | Closes the current second; a block in the same cycle opens the next one |
| sec_valid | output | 1 | One-cycle pulse: a second's record is on the outputs |
| sec_es | output | 1 | Errored second |
| sec_ses | output | 1 | Severely errored second |
| sec_uas | output | 1 | Unavailable second |
| sec_bbe | output | BLK_W | Background block errors in the reported second |
| es_total | output | TOT_W | Running count of errored seconds |
| ses_total | output | TOT_W | Running count of severely errored seconds |
| uas_total | output | TOT_W | Running count of unavailable seconds |
| bbe_total | output | TOT_W | Running count of background block errors |
| cses_total | output | TOT_W | Running count of consecutive-SES events |
| sd_alarm | output | 1 | Signal-degrade alarm |
| exc_alarm | output | 1 | Excessive-error alarm |

## Verification
A second's record is due on the falling edge after the third rising edge following the tick that pushes second k+RUN_LEN. The tick is registered in the accumulator, then in the holding line, then in the output stage. The bench keeps a three-deep history of sampled ticks and checks that a tick sits exactly three edges back whenever `sec_valid` is seen. Records are compared in order against a queue that the driver fills from its own model of the labelling. The alarm outputs are due on the falling edge right after the edge that accepts the window's last block, and they are sampled there.

// File: rtl/esc_pkg.sv
package esc_pkg;

    // width of per-second block and error counts (covers 8000 blocks per second)
    localparam int BLK_W = 14;

    typedef struct packed {
        logic             es;
        logic             ses;
        logic [BLK_W-1:0] errs;
    } sec_meas_t;

    typedef struct packed {
        logic      uas;
        sec_meas_t meas;
    } sec_lbl_t;

endpackage

// File: rtl/esc_sec_accum.sv
module esc_sec_accum
    import esc_pkg::*;
#(
    parameter int SDP_LEN = 8,
    parameter int SES_PCT = 30
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      blk_valid,
    input  logic      blk_err,
    input  logic      sig_loss,
    input  logic      sec_tick,
    output logic      meas_vld,
    output sec_meas_t meas
);
    localparam int RUN_W  = $clog2(SDP_LEN + 1);
    localparam int PROD_W = BLK_W + 8;
    localparam logic [BLK_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [BLK_W-1:0] blk_cnt;
        logic [BLK_W-1:0] err_cnt;
        logic [RUN_W-1:0] run;
        logic             sdp;
        logic             meas_vld;
        sec_meas_t        meas;
    } acc_t;

    acc_t d, q;
    logic              bad, hit;
    logic [RUN_W-1:0]  run_nxt;
    logic [PROD_W-1:0] err_scaled, blk_scaled;

    always_comb begin
        d          = q;
        d.meas_vld = 1'b0;
        bad        = blk_valid & (blk_err | sig_loss);
        run_nxt    = q.run;
        if (blk_valid) begin
            if (!bad)
                run_nxt = '0;
            else if (q.run != RUN_W'(SDP_LEN))
                run_nxt = q.run + RUN_W'(1);
        end
        hit        = bad && (run_nxt == RUN_W'(SDP_LEN));
        err_scaled = PROD_W'(q.err_cnt) * PROD_W'(100);
        blk_scaled = PROD_W'(q.blk_cnt) * PROD_W'(SES_PCT);
        d.run      = run_nxt;

        if (sec_tick) begin
            d.meas_vld  = 1'b1;
            d.meas.errs = q.err_cnt;
            d.meas.es   = (q.err_cnt != '0);
            d.meas.ses  = q.sdp || (err_scaled > blk_scaled);
            d.blk_cnt   = BLK_W'(blk_valid);
            d.err_cnt   = BLK_W'(bad);
            d.sdp       = hit;
        end else begin
            if (blk_valid && q.blk_cnt != CNT_MAX)
                d.blk_cnt = q.blk_cnt + BLK_W'(1);
            if (bad && q.err_cnt != CNT_MAX)
                d.err_cnt = q.err_cnt + BLK_W'(1);
            d.sdp = q.sdp | hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign meas_vld = q.meas_vld;
    assign meas     = q.meas;

    assert_err_within_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.err_cnt <= q.blk_cnt);

    assert_ses_needs_errors_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.meas_vld && q.meas.ses) |-> q.meas.es);

endmodule

// File: rtl/esc_avail_line.sv
module esc_avail_line
    import esc_pkg::*;
#(
    parameter int RUN_LEN = 10
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      meas_vld,
    input  sec_meas_t meas,
    output logic      pop_vld,
    output sec_lbl_t  pop
);
    localparam int RW = $clog2(RUN_LEN + 1);

    typedef struct packed {
        sec_lbl_t [RUN_LEN-1:0] line;
        logic [RW-1:0]          fill;
        logic                   unav;
        logic [RW-1:0]          run;
        logic                   pop_vld;
        sec_lbl_t               pop;
    } line_t;

    line_t d, q;
    logic  enter, leave;

    always_comb begin
        d         = q;
        d.pop_vld = 1'b0;
        enter     = 1'b0;
        leave     = 1'b0;
        if (meas_vld) begin
            d.pop_vld = (q.fill == RW'(RUN_LEN));
            d.pop     = q.line[RUN_LEN-1];
            for (int i = RUN_LEN - 1; i > 0; i--)
                d.line[i] = q.line[i-1];
            d.line[0].uas  = q.unav;
            d.line[0].meas = meas;
            if (q.fill != RW'(RUN_LEN))
                d.fill = q.fill + RW'(1);
            // available: count severe seconds; unavailable: count clean ones
            if (q.unav == meas.ses) begin
                d.run = '0;
            end else if (q.run == RW'(RUN_LEN - 1)) begin
                d.run  = '0;
                d.unav = !q.unav;
                enter  = !q.unav;
                leave  = q.unav;
            end else begin
                d.run = q.run + RW'(1);
            end
            for (int i = 0; i < RUN_LEN; i++) begin
                if (enter) d.line[i].uas = 1'b1;
                if (leave) d.line[i].uas = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pop_vld = q.pop_vld;
    assign pop     = q.pop;

    assert_run_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.run < RW'(RUN_LEN));

    assert_enter_after_severe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.unav) |-> $past(meas_vld && meas.ses));

    assert_leave_after_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.unav) |-> $past(meas_vld && !meas.ses));

endmodule

// File: rtl/esc_ratio_alarm.sv
module esc_ratio_alarm #(
    parameter int WIN_BLK = 8000000,
    parameter int SD_DIV  = 1000000,
    parameter int EXC_DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic blk_valid,
    input  logic blk_bad,
    output logic sd_alarm,
    output logic exc_alarm
);
    localparam int WIN_W   = $clog2(WIN_BLK + 1);
    localparam int SD_RAW  = WIN_BLK / SD_DIV;
    localparam int EXC_RAW = WIN_BLK / EXC_DIV;
    localparam int SD_LIM  = (SD_RAW > 0) ? SD_RAW : 1;
    localparam int EXC_LIM = (EXC_RAW > 0) ? EXC_RAW : 1;

    typedef struct packed {
        logic [WIN_W-1:0] win_cnt;
        logic [WIN_W-1:0] err_cnt;
        logic             sd;
        logic             exc;
    } win_t;

    win_t d, q;
    logic [WIN_W-1:0] err_sum;

    always_comb begin
        d       = q;
        err_sum = q.err_cnt + WIN_W'(blk_bad);
        if (blk_valid) begin
            if (q.win_cnt == WIN_W'(WIN_BLK - 1)) begin
                d.sd      = (err_sum >= WIN_W'(SD_LIM));
                d.exc     = (err_sum >= WIN_W'(EXC_LIM));
                d.win_cnt = '0;
                d.err_cnt = '0;
            end else begin
                d.win_cnt = q.win_cnt + WIN_W'(1);
                d.err_cnt = err_sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sd_alarm  = q.sd;
    assign exc_alarm = q.exc;

    assert_exc_implies_sd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        q.exc |-> q.sd);

    assert_window_errors_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.err_cnt <= q.win_cnt);

endmodule

// File: rtl/err_second_classifier.sv
module err_second_classifier
    import esc_pkg::*;
#(
    parameter int SDP_LEN = 8,
    parameter int SES_PCT = 30,
    parameter int RUN_LEN = 10,
    parameter int WIN_BLK = 8000000,
    parameter int SD_DIV  = 1000000,
    parameter int EXC_DIV = 1000,
    parameter int TOT_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_valid,
    input  logic             blk_err,
    input  logic             sig_loss,
    input  logic             sec_tick,
    output logic             sec_valid,
    output logic             sec_es,
    output logic             sec_ses,
    output logic             sec_uas,
    output logic [BLK_W-1:0] sec_bbe,
    output logic [TOT_W-1:0] es_total,
    output logic [TOT_W-1:0] ses_total,
    output logic [TOT_W-1:0] uas_total,
    output logic [TOT_W-1:0] bbe_total,
    output logic [TOT_W-1:0] cses_total,
    output logic             sd_alarm,
    output logic             exc_alarm
);
    localparam int SRW = $clog2(RUN_LEN + 1);

    typedef struct packed {
        logic             valid;
        logic             es;
        logic             ses;
        logic             uas;
        logic [BLK_W-1:0] bbe;
        logic [TOT_W-1:0] es_tot;
        logic [TOT_W-1:0] ses_tot;
        logic [TOT_W-1:0] uas_tot;
        logic [TOT_W-1:0] bbe_tot;
        logic [TOT_W-1:0] cses_tot;
        logic [SRW-1:0]   ses_run;
    } out_t;

    logic      meas_vld, pop_vld;
    sec_meas_t meas;
    sec_lbl_t  pop;

    esc_sec_accum #(.SDP_LEN(SDP_LEN), .SES_PCT(SES_PCT)) u_accum (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_err(blk_err),
        .sig_loss(sig_loss), .sec_tick(sec_tick), .meas_vld(meas_vld), .meas(meas)
    );

    esc_avail_line #(.RUN_LEN(RUN_LEN)) u_line (
        .clk(clk), .rst_n(rst_n), .meas_vld(meas_vld), .meas(meas),
        .pop_vld(pop_vld), .pop(pop)
    );

    esc_ratio_alarm #(.WIN_BLK(WIN_BLK), .SD_DIV(SD_DIV), .EXC_DIV(EXC_DIV)) u_alarm (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid),
        .blk_bad(blk_err | sig_loss), .sd_alarm(sd_alarm), .exc_alarm(exc_alarm)
    );

    out_t d, q;
    logic avail, es_now, ses_now;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.es    = 1'b0;
        d.ses   = 1'b0;
        d.uas   = 1'b0;
        d.bbe   = '0;
        avail   = !pop.uas;
        es_now  = pop.meas.es & avail;
        ses_now = pop.meas.ses & avail;
        if (pop_vld) begin
            d.valid    = 1'b1;
            d.es       = es_now;
            d.ses      = ses_now;
            d.uas      = pop.uas;
            d.bbe      = (avail && !pop.meas.ses) ? pop.meas.errs : '0;
            d.es_tot   = q.es_tot  + TOT_W'(es_now);
            d.ses_tot  = q.ses_tot + TOT_W'(ses_now);
            d.uas_tot  = q.uas_tot + TOT_W'(pop.uas);
            d.bbe_tot  = q.bbe_tot + TOT_W'(d.bbe);
            if (ses_now) begin
                if (q.ses_run != SRW'(RUN_LEN))
                    d.ses_run = q.ses_run + SRW'(1);
            end else begin
                if (q.ses_run >= SRW'(2))
                    d.cses_tot = q.cses_tot + TOT_W'(1);
                d.ses_run = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sec_valid  = q.valid;
    assign sec_es     = q.es;
    assign sec_ses    = q.ses;
    assign sec_uas    = q.uas;
    assign sec_bbe    = q.bbe;
    assign es_total   = q.es_tot;
    assign ses_total  = q.ses_tot;
    assign uas_total  = q.uas_tot;
    assign bbe_total  = q.bbe_tot;
    assign cses_total = q.cses_tot;

    assert_uas_adds_no_bbe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_valid && sec_uas) |-> (bbe_total == $past(bbe_total)));

    assert_es_total_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (es_total == $past(es_total)) || (es_total == $past(es_total) + TOT_W'(1)));

    assert_ses_within_es_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_valid && sec_ses) |-> sec_es);

    assert_totals_move_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_valid |-> $stable(uas_total));

endmodule

// File: tb/sim_err_second_classifier.sv
module sim_err_second_classifier;
    import esc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 40;
    localparam int SDP_LEN    = 8;
    localparam int SES_PCT    = 30;
    localparam int RUN_LEN    = 10;
    localparam int WIN_BLK    = 100;
    localparam int SD_DIV     = 100;
    localparam int EXC_DIV    = 10;
    localparam int TOT_W      = 32;

    logic clk, rst_n, blk_valid, blk_err, sig_loss, sec_tick;
    logic sec_valid, sec_es, sec_ses, sec_uas, sd_alarm, exc_alarm;
    logic [BLK_W-1:0] sec_bbe;
    logic [TOT_W-1:0] es_total, ses_total, uas_total, bbe_total, cses_total;

    err_second_classifier #(
        .SDP_LEN(SDP_LEN), .SES_PCT(SES_PCT), .RUN_LEN(RUN_LEN),
        .WIN_BLK(WIN_BLK), .SD_DIV(SD_DIV), .EXC_DIV(EXC_DIV), .TOT_W(TOT_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_err(blk_err),
        .sig_loss(sig_loss), .sec_tick(sec_tick), .sec_valid(sec_valid),
        .sec_es(sec_es), .sec_ses(sec_ses), .sec_uas(sec_uas), .sec_bbe(sec_bbe),
        .es_total(es_total), .ses_total(ses_total), .uas_total(uas_total),
        .bbe_total(bbe_total), .cses_total(cses_total),
        .sd_alarm(sd_alarm), .exc_alarm(exc_alarm)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    task automatic check_eq(string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    typedef struct {
        bit es;
        bit ses;
        bit uas;
        int bbe;
        int idx;
    } exp_t;

    exp_t exp_q[$];

    // scenario: errored-block count, burst placement, loss-of-signal source
    int sn[128];
    bit sb[128];
    bit sl[128];
    bit sev[128];
    bit lab[128];
    int ns = 0;

    task automatic add_sec(int n, bit burst, bit los);
        sn[ns] = n;
        sb[ns] = burst;
        sl[ns] = los;
        ns++;
    endtask

    logic [2:0] tick_hist;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_hist <= '0;
        else        tick_hist <= {tick_hist[1:0], sec_tick};
    end

    // monitor: pops one expected record per reported second
    always @(negedge clk) begin
        if (rst_n && sec_valid) begin
            if (exp_q.size() == 0) begin
                check_eq("R9 record with no second pending", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check_eq($sformatf("R9 sec %0d latency after tick", e.idx), tick_hist[2], 1);
                check_eq($sformatf("R1 R4 sec %0d es", e.idx), sec_es, e.es);
                check_eq($sformatf("R2 R3 sec %0d ses", e.idx), sec_ses, e.ses);
                check_eq($sformatf("R5 R6 sec %0d uas", e.idx), sec_uas, e.uas);
                check_eq($sformatf("R7 sec %0d bbe", e.idx), sec_bbe, e.bbe);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog expired: actual 1 expected 0");
        finish_run();
    end

    task automatic drive_block(bit e, bit l);
        blk_valid = 1'b1;
        blk_err   = e;
        sig_loss  = l;
        @(posedge clk);
        #1;
    endtask

    task automatic drive_second(int n, bit burst, bit los);
        for (int b = 0; b < NB; b++) begin
            bit bad;
            if (burst) bad = (b >= 2) && (b < 2 + n);
            else       bad = (b >= 2) && (((b - 2) % 2) == 0) && (((b - 2) / 2) < n);
            drive_block(bad & !los, bad & los);
        end
        blk_valid = 1'b0;
        blk_err   = 1'b0;
        sig_loss  = 1'b0;
        sec_tick  = 1'b1;
        @(posedge clk);
        #1;
        sec_tick  = 1'b0;
    endtask

    task automatic drive_window(int n);
        for (int b = 0; b < WIN_BLK; b++)
            drive_block(b < n, 1'b0);
        blk_valid = 1'b0;
        blk_err   = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_reset_state(string tag);
        @(negedge clk);
        check_eq({tag, " R13 outputs idle"},
                 {sec_valid, sec_es, sec_ses, sec_uas, sd_alarm, exc_alarm}, 0);
        check_eq({tag, " R13 totals zero"},
                 es_total + ses_total + uas_total + bbe_total + cses_total + sec_bbe, 0);
    endtask

    initial begin
        int unav, run, srun;
        int t_es, t_ses, t_uas, t_bbe, t_cses;
        blk_valid = 1'b0;
        blk_err   = 1'b0;
        sig_loss  = 1'b0;
        sec_tick  = 1'b0;
        rst_n     = 1'b0;
        repeat (3) @(posedge clk);
        check_reset_state("start");
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        add_sec(0, 0, 0);
        add_sec(3, 0, 0);
        add_sec(12, 0, 0);
        add_sec(13, 0, 0);
        add_sec(7, 1, 0);
        add_sec(8, 1, 0);
        add_sec(8, 1, 1);
        add_sec(0, 0, 0);
        add_sec(20, 1, 0);
        add_sec(20, 1, 0);
        add_sec(0, 0, 0);
        add_sec(2, 0, 0);
        for (int i = 0; i < 13; i++) add_sec(20, 1, 0);
        for (int i = 0; i < 4; i++)  add_sec(3, 0, 0);
        for (int i = 0; i < 10; i++) add_sec(0, 0, 0);
        for (int i = 0; i < 9; i++)  add_sec(9, 1, 0);
        add_sec(1, 0, 0);
        for (int i = 0; i < RUN_LEN; i++) add_sec(0, 0, 0);

        // labelling model from R2 R3 R5 R6
        unav = 0;
        run  = 0;
        for (int i = 0; i < ns; i++) begin
            sev[i] = (sn[i] * 100 > SES_PCT * NB) || (sb[i] && sn[i] >= SDP_LEN);
            lab[i] = (unav != 0);
            if ((unav != 0) == sev[i]) begin
                run = 0;
            end else begin
                run++;
                if (run == RUN_LEN) begin
                    run  = 0;
                    unav = (unav != 0) ? 0 : 1;
                    for (int j = i - RUN_LEN + 1; j <= i; j++) lab[j] = (unav != 0);
                end
            end
        end

        t_es = 0; t_ses = 0; t_uas = 0; t_bbe = 0; t_cses = 0; srun = 0;
        for (int i = 0; i < ns - RUN_LEN; i++) begin
            exp_t e;
            e.idx = i;
            e.uas = lab[i];
            e.es  = (sn[i] > 0) && !lab[i];
            e.ses = sev[i] && !lab[i];
            e.bbe = (!lab[i] && !sev[i]) ? sn[i] : 0;
            exp_q.push_back(e);
            t_es  += int'(e.es);
            t_ses += int'(e.ses);
            t_uas += int'(e.uas);
            t_bbe += e.bbe;
            if (e.ses) begin
                srun++;
            end else begin
                if (srun >= 2) t_cses++;
                srun = 0;
            end
        end

        for (int i = 0; i < ns; i++)
            drive_second(sn[i], sb[i], sl[i]);
        repeat (6) @(posedge clk);
        @(negedge clk);
        check_eq("R9 all seconds reported", exp_q.size(), 0);
        check_eq("R10 es_total", es_total, t_es);
        check_eq("R10 ses_total", ses_total, t_ses);
        check_eq("R10 R5 uas_total", uas_total, t_uas);
        check_eq("R10 R7 bbe_total", bbe_total, t_bbe);
        check_eq("R8 cses_total", cses_total, t_cses);

        // alarm windows after a fresh reset
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        check_reset_state("mid");
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        drive_window(0);
        check_eq("R11 clean window sd", sd_alarm, 0);
        check_eq("R12 clean window exc", exc_alarm, 0);
        @(posedge clk); #1;
        drive_window(1);
        check_eq("R11 one error sd", sd_alarm, 1);
        check_eq("R12 one error exc", exc_alarm, 0);
        @(posedge clk); #1;
        drive_window(9);
        check_eq("R12 below limit exc", exc_alarm, 0);
        @(posedge clk); #1;
        drive_window(10);
        check_eq("R12 at limit exc", exc_alarm, 1);
        check_eq("R11 at exc limit sd", sd_alarm, 1);
        @(posedge clk); #1;
        drive_window(0);
        check_eq("R11 clear sd", sd_alarm, 0);
        check_eq("R12 clear exc", exc_alarm, 0);

        finish_run();
    end

endmodule